// File: doc/BRIEF.md
# Self-Timed Nonvolatile Array Programming Sequencer

This block is the engine behind a small serial nonvolatile memory. A serial front end decodes a command and then, on the chip-select falling edge, pulses a commit strobe with the operation, a word address and a data word. From that point the block runs the whole programming cycle on its own, counted in system-clock ticks. No serial clock activity is needed, and chip select has no further influence. It holds a programming-enable latch that guards all erase and write work. It owns the word array and drives a busy flag.

A word write always clears the target word to all ones before it loads the new data. A whole-array write likewise runs a full clear before it fills every location with the same word. Array-wide passes visit one location per clock. The read port is registered and works at any time, whatever the state of the latch or the busy flag. Reset models the supply monitor. It clears the latch and the sequencer but leaves the array contents alone.

The cycle lengths are parameters. `T_WORD` must be even and at least 4. `T_ERAL` must exceed `DEPTH`. `T_WRAL/2` must exceed `DEPTH`.

Top module: `eeprom_prog_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it, `busy` is 0 and the enable latch is clear. Array contents survive a reset.
- R2: `cmd_op` codes are 0 none, 1 enable, 2 disable, 3 erase word, 4 write word, 5 erase all, 6 write all, and 7 is treated as none. A commit with code 1 sets the latch and a commit with code 2 clears it. A commit with code 3 to 6 while the latch is clear starts nothing: `busy` stays 0 and the array is unchanged.
- R3: An erase-word cycle sets every bit of the addressed word to 1 and leaves every other word untouched. `busy` is high for exactly `T_WORD` cycles.
- R4: A write-word cycle first writes all ones to the addressed word, `T_WORD/2` cycles after the commit. It then writes the supplied data at the end of the cycle. `busy` is high for exactly `T_WORD` cycles.
- R5: An erase-all cycle leaves every location at all ones. `busy` is high for exactly `T_ERAL` cycles.
- R6: A write-all cycle first sets every location to all ones over its first `T_WRAL/2` cycles. It then loads the supplied word into every location. `busy` is high for exactly `T_WRAL` cycles.
- R7: Every commit that arrives while `busy` is high is ignored, including enable and disable commits.
- R8: `rd_data` returns the word at `rd_addr` one clock later. This holds whatever the latch state and also while a cycle is running.
- R9: `busy` rises on the clock edge that samples an accepted commit. It falls on the same edge as the final array update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (supply monitor) |
| cmd_valid | input | 1 | One-cycle commit strobe |
| cmd_op | input | 3 | Decoded operation code |
| cmd_addr | input | AW | Word address for word operations |
| cmd_data | input | DW | Data word for write operations |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data |
| busy | output | 1 | High while a programming cycle runs |

## Verification
The assertions assume that `cmd_valid` is a single-cycle pulse. They also assume that the cycle-length parameters leave room for every sweep, so each wait phase lasts at least one cycle. The bench drives every commit as a one-cycle pulse at a falling clock edge. Where it issues commits during a running cycle, it does so only to show that they are ignored. It samples mid-cycle reads at fixed offsets from the commit edge, so the clearing write and the data write are seen in their order.

// File: rtl/epsq_pkg.sv
package epsq_pkg;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_UNLOCK   = 3'd1,
    OP_LOCK     = 3'd2,
    OP_CLR_WORD = 3'd3,
    OP_PUT_WORD = 3'd4,
    OP_CLR_ALL  = 3'd5,
    OP_PUT_ALL  = 3'd6,
    OP_RSVD     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SWEEP = 2'd2
  } st_e;

  function automatic logic op_programs(op_e op);
    return (op == OP_CLR_WORD) || (op == OP_PUT_WORD) ||
           (op == OP_CLR_ALL)  || (op == OP_PUT_ALL);
  endfunction

  function automatic logic op_two_pass(op_e op);
    return (op == OP_PUT_WORD) || (op == OP_PUT_ALL);
  endfunction

  function automatic logic op_whole(op_e op);
    return (op == OP_CLR_ALL) || (op == OP_PUT_ALL);
  endfunction

endpackage

// File: rtl/epsq_wen_latch.sv
module epsq_wen_latch
  import epsq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  op_e  op,
  output logic wen
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wen <= 1'b0;
    end else if (accept) begin
      if (op == OP_UNLOCK)    wen <= 1'b1;
      else if (op == OP_LOCK) wen <= 1'b0;
    end
  end

endmodule

// File: rtl/epsq_timer.sv
module epsq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/epsq_array.sv
module epsq_array #(
  parameter int DEPTH = 128,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/epsq_ctrl.sv
module epsq_ctrl
  import epsq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DW     = 16,
  parameter int AW     = $clog2(DEPTH),
  parameter int T_WORD = 40,
  parameter int T_ERAL = 200,
  parameter int T_WRAL = 400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          wen,
  output logic          accept,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);

  // wait-phase lengths; each pass lasts wait + sweep length
  localparam int W_W1  = T_WORD - 1;
  localparam int W_W2  = T_WORD / 2 - 1;
  localparam int W_A1  = T_ERAL - DEPTH;
  localparam int W_A2  = T_WRAL / 2 - DEPTH;
  localparam int W_M1  = (W_W1 > W_W2) ? W_W1 : W_W2;
  localparam int W_M2  = (W_A1 > W_A2) ? W_A1 : W_A2;
  localparam int W_MAX = (W_M1 > W_M2) ? W_M1 : W_M2;
  localparam int TW    = $clog2(W_MAX + 1) + 1;
  localparam logic [TW-1:0] L_W1 = TW'(W_W1 - 1);
  localparam logic [TW-1:0] L_W2 = TW'(W_W2 - 1);
  localparam logic [TW-1:0] L_A1 = TW'(W_A1 - 1);
  localparam logic [TW-1:0] L_A2 = TW'(W_A2 - 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  st_e           state;
  logic          two_pass;
  logic          whole;
  logic          prog_pass;
  logic [AW-1:0] ptr;
  logic [DW-1:0] dval;
  logic          start;
  logic          last_loc;
  logic          pass_turn;
  logic          t_load;
  logic [TW-1:0] t_val;
  logic          t_exp;

  assign accept    = cmd_valid && !busy;
  assign start     = accept && op_programs(op) && wen;
  assign last_loc  = !whole || (ptr == LAST);
  assign pass_turn = (state == ST_SWEEP) && last_loc && two_pass && !prog_pass;

  always_comb begin
    t_load = start || pass_turn;
    t_val  = L_W1;
    if (start) begin
      unique case (op)
        OP_PUT_WORD: t_val = L_W2;
        OP_CLR_ALL:  t_val = L_A1;
        OP_PUT_ALL:  t_val = L_A2;
        default:     t_val = L_W1;
      endcase
    end else begin
      t_val = whole ? L_A2 : L_W2;
    end
  end

  epsq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      two_pass  <= 1'b0;
      whole     <= 1'b0;
      prog_pass <= 1'b0;
      ptr       <= '0;
      dval      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_WAIT;
            busy      <= 1'b1;
            two_pass  <= op_two_pass(op);
            whole     <= op_whole(op);
            prog_pass <= 1'b0;
            ptr       <= op_whole(op) ? '0 : addr;
            dval      <= data;
          end
        end
        ST_WAIT: begin
          if (t_exp) state <= ST_SWEEP;
        end
        ST_SWEEP: begin
          if (last_loc) begin
            if (two_pass && !prog_pass) begin
              prog_pass <= 1'b1;
              if (whole) ptr <= '0;
              state <= ST_WAIT;
            end else begin
              state <= ST_IDLE;
              busy  <= 1'b0;
            end
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_we    = (state == ST_SWEEP);
  assign mem_waddr = ptr;
  assign mem_wdata = prog_pass ? dval : {DW{1'b1}};

  // R9: an accepted programming commit raises busy on the next cycle
  a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && wen && op_programs(op)) |=> busy);

  // R2: with the latch clear nothing starts
  a_r2_locked_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && !wen) |=> !busy);

  // R9: the array is only written while busy is reported
  a_r9_we_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R1: reset leaves the sequencer idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> !busy);

endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
  import epsq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DW     = 16,
  parameter int T_WORD = 40,
  parameter int T_ERAL = 200,
  parameter int T_WRAL = 400,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);

  op_e           op;
  logic          wen;
  logic          accept;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  assign op = op_e'(cmd_op);

  epsq_wen_latch u_wen (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .op     (op),
    .wen    (wen)
  );

  epsq_ctrl #(
    .DEPTH  (DEPTH),
    .DW     (DW),
    .AW     (AW),
    .T_WORD (T_WORD),
    .T_ERAL (T_ERAL),
    .T_WRAL (T_WRAL)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .op        (op),
    .addr      (cmd_addr),
    .data      (cmd_data),
    .wen       (wen),
    .accept    (accept),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  epsq_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R7: the enable latch cannot move while a cycle runs
  a_r7_latch_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(wen));

  // R1: reset clears the enable latch
  a_r1_latch_reset: assert property (@(posedge clk)
    rst |=> !wen);

endmodule

// File: tb/tb_eeprom_prog_seq.sv
module tb_eeprom_prog_seq;

  localparam int DEPTH  = 128;
  localparam int DW     = 16;
  localparam int AW     = $clog2(DEPTH);
  localparam int T_WORD = 40;
  localparam int T_ERAL = 200;
  localparam int T_WRAL = 400;
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          busy;

  int tests = 0;
  int fails = 0;
  int exp_q[$];
  bit finished = 0;

  always #4 clk = ~clk;

  eeprom_prog_seq #(
    .DEPTH(DEPTH), .DW(DW), .T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)
  ) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // driver: one-cycle commit; an accepted cycle pushes its expected busy length
  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input int exp_len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    if (exp_len > 0) exp_q.push_back(exp_len);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(rd_data === e, tag, int'(rd_data), int'(e));
  endtask

  // monitor: measures every busy pulse and compares with the scoreboard
  bit prev_busy = 0;
  int run_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) run_len++;
      if (!busy && prev_busy) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected busy pulse", run_len, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(run_len == e, "R9 busy length", run_len, e);
        end
        run_len = 0;
      end
      prev_busy = busy;
    end else begin
      prev_busy = 0;
      run_len = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int errs;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R1 busy during reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);

    // R2: locked latch ignores programming
    issue(3'd5, '0, '0, 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2 erase-all while locked", busy, 0);

    // R6: write all with mid-cycle check of the clearing pass
    issue(3'd1, '0, '0, 0);
    @(negedge clk); rd_addr = '0;
    issue(3'd6, '0, 16'hA5C3, T_WRAL);
    repeat (T_WRAL/2 + 2) @(negedge clk);
    check(rd_data === ONES, "R6 clear pass before fill", int'(rd_data), int'(ONES));
    wait_idle();
    read_chk(0, 16'hA5C3, "R6 fill addr 0");
    read_chk(63, 16'hA5C3, "R6 fill addr 63");
    read_chk(AW'(DEPTH-1), 16'hA5C3, "R6 fill last addr");

    // R4: write word with auto-erase ordering
    @(negedge clk); rd_addr = 5;
    issue(3'd4, 5, 16'h1234, T_WORD);
    repeat (T_WORD/2 - 1) @(negedge clk);
    check(rd_data === 16'hA5C3, "R4 old data before erase", int'(rd_data), 16'hA5C3);
    repeat (2) @(negedge clk);
    check(rd_data === ONES, "R4 auto-erase mid cycle", int'(rd_data), int'(ONES));
    wait_idle();
    read_chk(5, 16'h1234, "R4 written word");
    read_chk(6, 16'hA5C3, "R4 neighbour untouched");

    // R3: erase word
    issue(3'd3, 7, '0, T_WORD);
    wait_idle();
    read_chk(7, ONES, "R3 erased word");
    read_chk(8, 16'hA5C3, "R3 neighbour untouched");

    // R2: disable then erase is ignored; R8 read while locked
    issue(3'd2, '0, '0, 0);
    issue(3'd3, 5, '0, 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2 erase after disable", busy, 0);
    read_chk(5, 16'h1234, "R2 R8 word kept while locked");

    // R1: reset keeps array, clears latch
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    read_chk(5, 16'h1234, "R1 array survives reset");
    issue(3'd3, 5, '0, 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 latch clear after reset", busy, 0);
    read_chk(5, 16'h1234, "R1 word kept after locked erase");

    // R7: commits during busy are ignored
    issue(3'd1, '0, '0, 0);
    issue(3'd4, 9, 16'h0F0F, T_WORD);
    issue(3'd4, 10, 16'h0000, 0);
    issue(3'd2, '0, '0, 0);
    wait_idle();
    read_chk(9, 16'h0F0F, "R7 first write done");
    read_chk(10, 16'hA5C3, "R7 write during busy ignored");
    issue(3'd3, 9, '0, T_WORD);
    wait_idle();
    read_chk(9, ONES, "R7 disable during busy ignored");

    // R5 with R8 read during a running cycle
    issue(3'd5, '0, '0, T_ERAL);
    read_chk(5, 16'h1234, "R8 read during busy");
    wait_idle();
    errs = 0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); rd_addr = AW'(i);
      @(negedge clk);
      if (rd_data !== ONES) errs++;
    end
    check(errs == 0, "R5 all locations erased", errs, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 all busy pulses seen", exp_q.size(), 0);
    report();
  end

endmodule